// File: doc/BRIEF.md
# Configuration Space Register File

This block is the configuration register file of a bus target. It holds the device's 256-byte configuration space: the 64-byte standard header at offsets 00h to 3Fh and a small device-specific region of read/write dwords starting at 40h. The target controller presents each address phase to the block. The block claims a configuration cycle only when the per-slot select line is high, the command is a configuration read or write, and the type field marks a local (Type 0) access. The address value plays no part in the claim.

Once an access is claimed, every data transfer reads or writes the dword at the current offset, and the offset then advances by one. A multi-dword burst therefore walks through consecutive registers. Writes follow the active-high byte-lane enables. Fields that software cannot change ignore writes, and offsets that are not implemented read as zero.

The block drives decoded controls to the rest of the device: the memory-space enable, the parity-error reporting enable, the base of the 4 KB memory window, and the interrupt line value that software assigns at start-up. The single memory base register is sized by masking. Its low bits are tied to zero, so writing all ones and reading the register back tells software how large the window is.

Top module: `cfgsp_regfile`

## Requirements
- R1: `claim` rises one cycle after an address phase (`addr_vld` high) with `idsel` high, `cmd` equal to 4'b1010 (read) or 4'b1011 (write) and `ad_lo[1:0]` equal to 2'b00. `claim` stays low after any other address phase. It falls in the cycle after the transfer that has `xfer_last` high.
- R2: Offset 00h reads {device ID 16'h3C21, vendor ID 16'hA55A}. Offset 08h reads {class 24'h058000, revision 8'h02}. Offset 2Ch reads {subsystem 16'h0001, subsystem vendor 16'h7E11}. Writes to these offsets are ignored.
- R3: Offset 04h bits 31:16 are the read-only status word. Bit 21 (66 MHz capable) equals the CAP66 parameter (default 1), and bit 20 (capability list present) is 1 when the capability pointer is nonzero. The command half (bits 15:0) reads 0 after reset.
- R4: Command bit 1 (memory space enable) and bit 6 (parity error reporting enable) are writable and drive `mem_en` and `perr_en`. All other command bits read 0.
- R5: Offset 10h is the memory base register of a 4 KB window. Bits 31:12 are writable and bits 11:0 read 0, so bit 0 = 0 marks memory space. Writing FFFFFFFFh reads back FFFFF000h. `bar_base` shows the register value.
- R6: A write changes only the bytes whose `lane_en` bit is 1 (bit n covers data bits 8n+7:8n).
- R7: Offset 3Ch bits 7:0 are the writable interrupt line, reset to 0 and driven on `int_line`. Bits 15:8 read the interrupt pin 8'h01, and bits 31:16 read 0.
- R8: Offset 34h bits 7:0 read the capability pointer 8'h40, and the rest of that dword reads 0.
- R9: Offsets 40h to 4Ch are four read/write device-specific dwords that reset to 0. All other offsets (0Ch, 14h to 28h, 30h, 38h, 50h to FCh) read 0.
- R10: Within a burst, each transfer uses the next dword offset after the previous transfer's offset.
- R11: `rdata` is 0 while `claim` is low, and a transfer (`xfer`) while `claim` is low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_vld | input | 1 | Address phase present on `cmd`/`ad_lo` |
| idsel | input | 1 | Per-slot configuration select |
| cmd | input | 4 | Bus command during the address phase |
| ad_lo | input | 8 | Address bits 7:0: dword offset in 7:2, type in 1:0 |
| xfer | input | 1 | Data transfer in this cycle (both sides ready) |
| xfer_last | input | 1 | This transfer is the final one |
| wdata | input | 32 | Write data |
| lane_en | input | 4 | Active-high byte-lane enables |
| claim | output | 1 | Access is claimed (device select) |
| rdata | output | 32 | Read data for the current offset |
| mem_en | output | 1 | Memory space enable |
| perr_en | output | 1 | Parity error reporting enable |
| bar_base | output | 32 | Memory window base address |
| int_line | output | 8 | Interrupt line assigned by software |

## Verification
A wrong offset pointer shows up in the very next read transfer as data from the wrong register. In a burst, it shows up from the second transfer onward. A corrupted control register, or a write that slips through on a disabled lane, shows up on `mem_en`, `perr_en`, `bar_base` or `int_line` one cycle after the offending transfer. It is confirmed again by the next read-back. A decode fault shows up as `claim` being wrong one cycle after the address phase. A session that never closes shows up as `claim` still high in the cycle after the last transfer.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;
  localparam int PTR_W = 6;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
  localparam logic [1:0] TYPE_LOCAL = 2'b00;

  localparam logic [PTR_W-1:0] DW_ID      = 6'd0;
  localparam logic [PTR_W-1:0] DW_STATCMD = 6'd1;
  localparam logic [PTR_W-1:0] DW_CLASS   = 6'd2;
  localparam logic [PTR_W-1:0] DW_BAR0    = 6'd4;
  localparam logic [PTR_W-1:0] DW_SUBSYS  = 6'd11;
  localparam logic [PTR_W-1:0] DW_CAPPTR  = 6'd13;
  localparam logic [PTR_W-1:0] DW_INTR    = 6'd15;
  localparam int               DW_USER0   = 16;

  localparam int CMD_MEM_BIT  = 1;
  localparam int CMD_PERR_BIT = 6;

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction
endpackage

// File: rtl/cfgsp_decode.sv
module cfgsp_decode
  import cfgsp_pkg::*;
(
  input  logic             clk,
  input  logic             nrst,
  input  logic             addr_vld,
  input  logic             idsel,
  input  logic [3:0]       cmd,
  input  logic [7:0]       ad_lo,
  input  logic             xfer,
  input  logic             xfer_last,
  output logic             active,
  output logic             is_wr,
  output logic [PTR_W-1:0] ptr
);
  logic             hit;
  logic             active_d, is_wr_d;
  logic [PTR_W-1:0] ptr_d;
  logic             ce;

  assign hit = addr_vld && idsel && (ad_lo[1:0] == TYPE_LOCAL) &&
               ((cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR));

  always_comb begin
    active_d = active;
    is_wr_d  = is_wr;
    ptr_d    = ptr;
    if (hit) begin
      active_d = 1'b1;
      is_wr_d  = (cmd == CMD_CFG_WR);
      ptr_d    = ad_lo[7:2];
    end else if (active && xfer) begin
      ptr_d = ptr + 1'b1;
      if (xfer_last) active_d = 1'b0;
    end
  end

  assign ce = hit || (active && xfer);

  always_ff @(posedge clk or negedge nrst) begin
    if (!nrst) begin
      active <= 1'b0;
      is_wr  <= 1'b0;
      ptr    <= '0;
    end else if (ce) begin
      active <= active_d;
      is_wr  <= is_wr_d;
      ptr    <= ptr_d;
    end
  end
endmodule

// File: rtl/cfgsp_hdr.sv
module cfgsp_hdr
  import cfgsp_pkg::*;
#(
  parameter logic [15:0] VEN_ID    = 16'hA55A,
  parameter logic [15:0] DEV_ID    = 16'h3C21,
  parameter logic [23:0] CLASS     = 24'h058000,
  parameter logic [7:0]  REV       = 8'h02,
  parameter logic [15:0] SUB_VEN   = 16'h7E11,
  parameter logic [15:0] SUB_ID    = 16'h0001,
  parameter logic [7:0]  INT_PIN   = 8'h01,
  parameter logic [7:0]  CAP_PTR   = 8'h40,
  parameter bit          CAP66     = 1'b1,
  parameter int          WIN_LOG2  = 12
) (
  input  logic             clk,
  input  logic             nrst,
  input  logic             wr_stb,
  input  logic [PTR_W-1:0] ptr,
  input  logic [31:0]      wdata,
  input  logic [3:0]       be,
  output logic [31:0]      hdr_rdata,
  output logic             mem_en,
  output logic             perr_en,
  output logic [31:0]      bar_base,
  output logic [7:0]       int_line
);
  localparam int BAR_W = 32 - WIN_LOG2;
  localparam logic CAPLIST = (CAP_PTR != 8'h00);

  logic [31:0]      wmask, cmd_word, bar_word;
  logic [BAR_W-1:0] bar_q, bar_d;
  logic             mem_d, perr_d;
  logic [7:0]       intl_d;
  logic             cmd_ce, bar_ce, intl_ce;

  assign wmask    = lane_mask(be);
  assign cmd_word = {25'b0, perr_en, 4'b0, mem_en, 1'b0};
  assign bar_word = {bar_q, {WIN_LOG2{1'b0}}};

  assign cmd_ce  = wr_stb && (ptr == DW_STATCMD);
  assign bar_ce  = wr_stb && (ptr == DW_BAR0);
  assign intl_ce = wr_stb && (ptr == DW_INTR) && be[0];

  always_comb begin
    logic [31:0] c_n, b_n;
    c_n    = (cmd_word & ~wmask) | (wdata & wmask);
    b_n    = (bar_word & ~wmask) | (wdata & wmask);
    mem_d  = c_n[CMD_MEM_BIT];
    perr_d = c_n[CMD_PERR_BIT];
    bar_d  = b_n[31:WIN_LOG2];
    intl_d = wdata[7:0];
  end

  always_ff @(posedge clk or negedge nrst) begin
    if (!nrst) begin
      mem_en  <= 1'b0;
      perr_en <= 1'b0;
    end else if (cmd_ce) begin
      mem_en  <= mem_d;
      perr_en <= perr_d;
    end
  end

  always_ff @(posedge clk or negedge nrst) begin
    if (!nrst)       bar_q <= '0;
    else if (bar_ce) bar_q <= bar_d;
  end

  always_ff @(posedge clk or negedge nrst) begin
    if (!nrst)        int_line <= 8'h00;
    else if (intl_ce) int_line <= intl_d;
  end

  assign bar_base = bar_word;

  always_comb begin
    case (ptr)
      DW_ID:      hdr_rdata = {DEV_ID, VEN_ID};
      DW_STATCMD: hdr_rdata = {10'b0, CAP66, CAPLIST, 4'b0, cmd_word[15:0]};
      DW_CLASS:   hdr_rdata = {CLASS, REV};
      DW_BAR0:    hdr_rdata = bar_word;
      DW_SUBSYS:  hdr_rdata = {SUB_ID, SUB_VEN};
      DW_CAPPTR:  hdr_rdata = {24'b0, CAP_PTR};
      DW_INTR:    hdr_rdata = {16'b0, INT_PIN, int_line};
      default:    hdr_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/cfgsp_user.sv
module cfgsp_user
  import cfgsp_pkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic             clk,
  input  logic             nrst,
  input  logic             wr_stb,
  input  logic [PTR_W-1:0] ptr,
  input  logic [31:0]      wdata,
  input  logic [3:0]       be,
  output logic [31:0]      usr_rdata
);
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [31:0]      words_q [WORDS];
  logic [PTR_W-1:0] rel;
  logic             in_rng;
  logic [31:0]      wmask;

  assign rel    = ptr - PTR_W'(DW_USER0);
  assign in_rng = (ptr >= PTR_W'(DW_USER0)) && (rel < PTR_W'(WORDS));
  assign wmask  = lane_mask(be);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic        ce;
    logic [31:0] nxt;
    assign ce  = wr_stb && in_rng && (rel == PTR_W'(w));
    assign nxt = (words_q[w] & ~wmask) | (wdata & wmask);
    always_ff @(posedge clk or negedge nrst) begin
      if (!nrst)   words_q[w] <= 32'h0;
      else if (ce) words_q[w] <= nxt;
    end
  end

  assign usr_rdata = in_rng ? words_q[rel[IDX_W-1:0]] : 32'h0;
endmodule

// File: rtl/cfgsp_regfile.sv
module cfgsp_regfile
  import cfgsp_pkg::*;
#(
  parameter int USER_WORDS = 4,
  parameter int WIN_LOG2   = 12,
  parameter bit CAP66      = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_vld,
  input  logic        idsel,
  input  logic [3:0]  cmd,
  input  logic [7:0]  ad_lo,
  input  logic        xfer,
  input  logic        xfer_last,
  input  logic [31:0] wdata,
  input  logic [3:0]  lane_en,
  output logic        claim,
  output logic [31:0] rdata,
  output logic        mem_en,
  output logic        perr_en,
  output logic [31:0] bar_base,
  output logic [7:0]  int_line
);
  logic [1:0]       rst_sync;
  logic             nrst;
  logic             active, is_wr, wr_stb;
  logic [PTR_W-1:0] ptr;
  logic [31:0]      hdr_rdata, usr_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign nrst = rst_sync[1];

  cfgsp_decode u_dec (
    .clk(clk), .nrst(nrst), .addr_vld(addr_vld), .idsel(idsel), .cmd(cmd),
    .ad_lo(ad_lo), .xfer(xfer), .xfer_last(xfer_last),
    .active(active), .is_wr(is_wr), .ptr(ptr)
  );

  assign wr_stb = active && is_wr && xfer;

  cfgsp_hdr #(.CAP66(CAP66), .WIN_LOG2(WIN_LOG2)) u_hdr (
    .clk(clk), .nrst(nrst), .wr_stb(wr_stb), .ptr(ptr), .wdata(wdata),
    .be(lane_en), .hdr_rdata(hdr_rdata), .mem_en(mem_en), .perr_en(perr_en),
    .bar_base(bar_base), .int_line(int_line)
  );

  cfgsp_user #(.WORDS(USER_WORDS)) u_usr (
    .clk(clk), .nrst(nrst), .wr_stb(wr_stb), .ptr(ptr), .wdata(wdata),
    .be(lane_en), .usr_rdata(usr_rdata)
  );

  assign claim = active;
  assign rdata = active ? (hdr_rdata | usr_rdata) : 32'h0;
endmodule

// File: rtl/cfgsp_regfile_chk.sv
module cfgsp_regfile_chk (
  input logic        clk,
  input logic        nrst,
  input logic        addr_vld,
  input logic        idsel,
  input logic [3:0]  cmd,
  input logic [7:0]  ad_lo,
  input logic        xfer,
  input logic        xfer_last,
  input logic        claim,
  input logic [31:0] rdata,
  input logic        wr_stb,
  input logic        mem_en,
  input logic        perr_en,
  input logic [31:0] bar_base,
  input logic [7:0]  int_line
);
  assert_claim_rise_R1: assert property (@(posedge clk) disable iff (!nrst)
    $rose(claim) |-> $past(addr_vld && idsel && cmd[3:1] == 3'b101 && ad_lo[1:0] == 2'b00));

  assert_claim_fall_R1: assert property (@(posedge clk) disable iff (!nrst)
    (claim && xfer && xfer_last && !addr_vld) |=> !claim);

  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!nrst)
    !$past(wr_stb) |-> ($stable(mem_en) && $stable(perr_en)));

  assert_bar_hold_R5: assert property (@(posedge clk) disable iff (!nrst)
    !$past(wr_stb) |-> $stable(bar_base));

  assert_intl_hold_R7: assert property (@(posedge clk) disable iff (!nrst)
    !$past(wr_stb) |-> $stable(int_line));

  assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!nrst)
    !claim |-> (rdata == 32'h0));
endmodule

bind cfgsp_regfile cfgsp_regfile_chk u_chk (
  .clk(clk), .nrst(nrst), .addr_vld(addr_vld), .idsel(idsel), .cmd(cmd),
  .ad_lo(ad_lo), .xfer(xfer), .xfer_last(xfer_last), .claim(claim),
  .rdata(rdata), .wr_stb(wr_stb), .mem_en(mem_en), .perr_en(perr_en),
  .bar_base(bar_base), .int_line(int_line)
);

// File: tb/cfgsp_regfile_tb.sv
`timescale 1ns/1ps
module cfgsp_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        addr_vld, idsel, xfer, xfer_last;
  logic [3:0]  cmd, lane_en;
  logic [7:0]  ad_lo;
  logic [31:0] wdata;
  logic        claim, mem_en, perr_en;
  logic [31:0] rdata, bar_base;
  logic [7:0]  int_line;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t       sb [$];
  logic [31:0] wd [4];
  logic        tb_rd;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  cfgsp_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .idsel(idsel), .cmd(cmd),
    .ad_lo(ad_lo), .xfer(xfer), .xfer_last(xfer_last), .wdata(wdata),
    .lane_en(lane_en), .claim(claim), .rdata(rdata), .mem_en(mem_en),
    .perr_en(perr_en), .bar_base(bar_base), .int_line(int_line)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data as transfers occur
  always @(negedge clk) begin
    if (tb_rd && xfer) begin
      if (sb.size() == 0) check(1'b0, "scoreboard empty", rdata, 32'h0);
      else begin
        item_t it;
        it = sb.pop_front();
        check(rdata === it.exp, it.tag, rdata, it.exp);
      end
    end
  end

  // driver: one claimed access of n transfers; reads push wd[] as expected data
  task automatic run(input bit wr, input logic [7:0] off, input int n,
                     input logic [3:0] be, input string tag);
    @(posedge clk); #1;
    addr_vld = 1'b1; idsel = 1'b1; cmd = wr ? 4'b1011 : 4'b1010;
    ad_lo = {off[7:2], 2'b00};
    @(posedge clk); #1;
    addr_vld = 1'b0; idsel = 1'b0;
    for (int i = 0; i < n; i++) begin
      xfer = 1'b1; xfer_last = (i == n - 1); lane_en = be;
      wdata = wr ? wd[i] : 32'h0; tb_rd = !wr;
      if (!wr) sb.push_back('{wd[i], tag});
      if (i == 0) begin
        @(negedge clk);
        check(claim === 1'b1, "R1 claim on valid access", {31'b0, claim}, 32'h1);
      end
      @(posedge clk); #1;
    end
    xfer = 1'b0; xfer_last = 1'b0; tb_rd = 1'b0;
    @(negedge clk);
    check(claim === 1'b0, "R1 release after last", {31'b0, claim}, 32'h0);
  endtask

  task automatic wr1(input logic [7:0] off, input logic [31:0] d, input logic [3:0] be,
                     input string tag);
    wd[0] = d; run(1'b1, off, 1, be, tag);
  endtask

  task automatic rd1(input logic [7:0] off, input logic [31:0] e, input string tag);
    wd[0] = e; run(1'b0, off, 1, 4'hF, tag);
  endtask

  task automatic reject(input logic sel, input logic [3:0] c, input logic [7:0] a,
                        input string tag);
    @(posedge clk); #1;
    addr_vld = 1'b1; idsel = sel; cmd = c; ad_lo = a;
    @(posedge clk); #1;
    addr_vld = 1'b0; idsel = 1'b0;
    @(negedge clk);
    check(claim === 1'b0, tag, {31'b0, claim}, 32'h0);
    check(rdata === 32'h0, "R11 idle rdata", rdata, 32'h0);
  endtask

  initial begin
    #150000;
    if (!done) begin
      check(1'b0, "watchdog", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr_vld = 0; idsel = 0; cmd = 0; ad_lo = 0; xfer = 0;
    xfer_last = 0; wdata = 0; lane_en = 0; tb_rd = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(claim === 1'b0, "R1 reset claim", {31'b0, claim}, 32'h0);
    check(mem_en === 1'b0 && perr_en === 1'b0, "R3 reset command",
          {30'b0, perr_en, mem_en}, 32'h0);
    check(int_line === 8'h00, "R7 reset int line", {24'b0, int_line}, 32'h0);
    check(bar_base === 32'h0, "R5 reset base", bar_base, 32'h0);

    // R2 identity, read-only
    rd1(8'h00, 32'h3C21_A55A, "R2 id");
    rd1(8'h08, 32'h0580_0002, "R2 class");
    rd1(8'h2C, 32'h0001_7E11, "R2 subsystem");
    wr1(8'h00, 32'hFFFF_FFFF, 4'hF, "R2 write id");
    rd1(8'h00, 32'h3C21_A55A, "R2 id after write");
    wr1(8'h2C, 32'h0, 4'hF, "R2 write subsys");
    rd1(8'h2C, 32'h0001_7E11, "R2 subsys after write");

    // R3 / R4 status and command
    rd1(8'h04, 32'h0030_0000, "R3 status reset");
    wr1(8'h04, 32'hFFFF_FFFF, 4'hF, "R4 set cmd");
    rd1(8'h04, 32'h0030_0042, "R4 cmd bits");
    @(negedge clk);
    check(mem_en === 1'b1 && perr_en === 1'b1, "R4 enables on",
          {30'b0, perr_en, mem_en}, 32'h3);
    wr1(8'h04, 32'h0, 4'b0010, "R6 lane1 only");
    rd1(8'h04, 32'h0030_0042, "R6 cmd kept");
    wr1(8'h04, 32'h0, 4'b0001, "R4 clear cmd");
    rd1(8'h04, 32'h0030_0000, "R4 cmd cleared");
    @(negedge clk);
    check(mem_en === 1'b0 && perr_en === 1'b0, "R4 enables off",
          {30'b0, perr_en, mem_en}, 32'h0);

    // R5 memory base sizing
    wr1(8'h10, 32'hFFFF_FFFF, 4'hF, "R5 size probe");
    rd1(8'h10, 32'hFFFF_F000, "R5 size readback");
    wr1(8'h10, 32'h1234_5678, 4'hF, "R5 program");
    rd1(8'h10, 32'h1234_5000, "R5 base");
    wr1(8'h10, 32'hAB00_0000, 4'b1000, "R6 top lane");
    rd1(8'h10, 32'hAB34_5000, "R6 base lanes");
    @(negedge clk);
    check(bar_base === 32'hAB34_5000, "R5 bar_base out", bar_base, 32'hAB34_5000);

    // R8 capability pointer, R9 unimplemented
    rd1(8'h34, 32'h0000_0040, "R8 cap ptr");
    rd1(8'h0C, 32'h0, "R9 0Ch zero");
    rd1(8'h14, 32'h0, "R9 14h zero");
    rd1(8'h50, 32'h0, "R9 50h zero");

    // R9 / R10 user region bursts
    wd[0] = 32'h1111_1111; wd[1] = 32'h2222_2222;
    wd[2] = 32'h3333_3333; wd[3] = 32'h4444_4444;
    run(1'b1, 8'h40, 4, 4'hF, "R10 burst write");
    run(1'b0, 8'h40, 4, 4'hF, "R9 R10 burst read");
    wd[0] = 32'h0580_0002; wd[1] = 32'h0; wd[2] = 32'hAB34_5000;
    run(1'b0, 8'h08, 3, 4'hF, "R10 header burst");

    // R7 interrupt line
    wr1(8'h3C, 32'hFFFF_FF5A, 4'hF, "R7 write line");
    rd1(8'h3C, 32'h0000_015A, "R7 line and pin");
    @(negedge clk);
    check(int_line === 8'h5A, "R7 int_line out", {24'b0, int_line}, 32'h5A);

    // R11: pointer now rests at 40h; unclaimed transfer must not write it
    wr1(8'h3C, 32'h0000_005A, 4'h1, "R7 rewrite");
    @(posedge clk); #1;
    xfer = 1'b1; wdata = 32'hDEAD_BEEF; lane_en = 4'hF;
    @(negedge clk);
    check(rdata === 32'h0, "R11 rdata unclaimed", rdata, 32'h0);
    @(posedge clk); #1;
    xfer = 1'b0;
    rd1(8'h40, 32'h1111_1111, "R11 no write unclaimed");

    // R1 rejected address phases
    reject(1'b0, 4'b1010, 8'h00, "R1 no idsel");
    reject(1'b1, 4'b1011, 8'h01, "R1 type 1");
    reject(1'b1, 4'b0110, 8'h00, "R1 memory command");

    if (sb.size() != 0) check(1'b0, "scoreboard leftover", sb.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule